// File: doc/BRIEF.md
# Entropy-Scored Threshold Search

This block looks for the single scalar cut that best separates two equally sized classes of one-dimensional training samples. It sweeps a candidate threshold from a start value towards a ceiling in fixed increments. For each candidate it receives the whole sample set once more from its host. It tallies how many samples of each class land below and at-or-above the cut. From those tallies it forms an information index through a small lookup table of p·log(p) values. The candidate with the highest index is kept.

The host talks to it through a word handshake. A one-cycle `start` pulse begins a search. While `req` is high, the host presents 32-bit words with `word_valid`, and each word carries one sample of each class. After the last word of a pass, `req` drops while the score is formed. It rises again when the next candidate is ready to be fed. When the final candidate has been scored, `done` rises and stays high, and `oe` pulses once to mark `best_thr` and `best_score` as the final result.

Top module: `ent_threshold_search`

## Requirements
- R1: In each accepted word, bits [9:0] hold the class-one sample and bits [29:20] hold the class-two sample, both unsigned. Bits [19:10] and [31:30] have no effect on any output.
- R2: A sample counts as above the current threshold when it is greater than or equal to the threshold, and as below otherwise. A sample equal to the threshold therefore counts as above.
- R3: Each probability term is read from a 32-entry table, where entry q holds round(128·(q/32)·log2(32/q)) and entry 0 holds 0. A tally x is mapped to q = floor(x·32/(2N)), with N = 16 samples per class. A q of 32 or more contributes 0.
- R4: With a and b the tallies of class one and class two on one side, the index loss is ΔE = h(c1 below) + h(c1 above) + h(c2 below) + h(c2 above) − h(c1 below + c2 below) − h(c1 above + c2 above). Because the classes are equal in size, the normalizer is one bit, which is represented as 128. The score is 128 − ΔE, clamped to the range 0 to 128.
- R5: The thresholds visited are 0, 16, 32 and so on. A candidate is the last one when 1008 minus it is less than 16, so the default sweep has 64 candidates.
- R6: After each candidate is scored, the stored best is replaced only when the new score is strictly greater. The first candidate of a search is always stored. On a tie, the lower threshold is therefore kept.
- R7: `start` restarts the search from any state. In the following cycle, `req` is high, `done` is low and `best_score` and `best_thr` are zero.
- R8: A word is taken at a rising edge where `req` and `word_valid` are both high. After the 16th word of a pass, `req` is low from the next cycle on. It returns high 8 clock edges after the edge that took that word, unless that pass was the last. Words offered while `req` is low are ignored.
- R9: `done` rises 8 clock edges after the final word of the last pass is taken, and it holds until the next `start`. `oe` is high only in the first cycle of `done`. `req` stays low while `done` is high.
- R10: After reset, `req`, `done` and `oe` are low and `best_thr` and `best_score` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a new search |
| word_valid | input | 1 | Host offers a sample word |
| word_in | input | 32 | Sample word: class one in [9:0], class two in [29:20] |
| req | output | 1 | Block is collecting sample words for the current candidate |
| done | output | 1 | Search finished; result is final |
| oe | output | 1 | One-cycle marker of a fresh final result |
| best_thr | output | 10 | Threshold with the highest score so far |
| best_score | output | 8 | Highest score so far, 0 to 128 |

## Verification
The hardest situations to reach from the ports are exact score ties and samples sitting exactly on a candidate threshold. A wrong tie rule or a wrong equality rule only shows up in those cases, and random data almost never lands there.

The stimulus therefore includes several special sample sets:
- a set where every class-one sample equals a candidate value and every class-two sample sits one below it;
- a set where both classes are identical, so many candidates score alike;
- sets with clean, reversed and overlapping separation.

Passes are also fed with random stalls and with garbage words offered while `req` is low. A search is aborted partway so that a restart has to clear a non-zero best.

// File: rtl/ent_pkg.sv
`timescale 1ns/1ps
package ent_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CALC,
    ST_JUDGE,
    ST_FIN
  } ent_state_t;

  // number of table lookups per candidate: four joint terms, two side terms
  localparam int TERMS = 6;
endpackage

// File: rtl/ent_plogp_rom.sv
`timescale 1ns/1ps
// Table of scaled -p*log2(p) values, p = addr / 2**AW, registered read port.
module ent_plogp_rom #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  localparam int ONE   = 1 << (DW - 1);

  logic [DW-1:0] mem [0:DEPTH-1];

  initial begin
    mem[0] = '0;
    for (int i = 1; i < DEPTH; i++) begin
      mem[i] = DW'($rtoi(real'(ONE) * (real'(i) / real'(DEPTH)) *
                         ($ln(real'(DEPTH) / real'(i)) / $ln(2.0)) + 0.5));
    end
  end

  always_ff @(posedge clk) begin
    q <= mem[addr];
  end
endmodule

// File: rtl/ent_tally.sv
`timescale 1ns/1ps
// Per-class below/above tallies for one pass, plus the word counter.
module ent_tally #(
  parameter int SW     = 10,
  parameter int N_LOG2 = 4,
  parameter int SUMW   = N_LOG2 + 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      take,
  input  logic [1:0][SW-1:0]        samp,
  input  logic [SW-1:0]             thr,
  output logic [1:0][SUMW-1:0]      below,
  output logic [1:0][SUMW-1:0]      above,
  output logic                      last
);
  logic [N_LOG2-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (take)  cnt <= cnt + 1'b1;
  end

  assign last = take && (&cnt);

  for (genvar c = 0; c < 2; c++) begin : g_cls
    logic [SUMW-1:0] lo_r, hi_r;
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        lo_r <= '0;
        hi_r <= '0;
      end else if (take) begin
        if (samp[c] >= thr) hi_r <= hi_r + 1'b1;
        else                lo_r <= lo_r + 1'b1;
      end
    end
    assign below[c] = lo_r;
    assign above[c] = hi_r;
  end
endmodule

// File: rtl/ent_term_pick.sv
`timescale 1ns/1ps
// Selects the tally for term k and quantizes it to a table address.
module ent_term_pick #(
  parameter int N_LOG2 = 4,
  parameter int AW     = 5,
  parameter int SUMW   = N_LOG2 + 2
) (
  input  logic [2:0]               k,
  input  logic [1:0][SUMW-1:0]     below,
  input  logic [1:0][SUMW-1:0]     above,
  output logic [AW-1:0]            addr,
  output logic                     skip,
  output logic                     neg
);
  logic [SUMW-1:0]    pick;
  logic [SUMW+AW-1:0] wide;

  always_comb begin
    case (k)
      3'd0:    pick = below[0];
      3'd1:    pick = above[0];
      3'd2:    pick = below[1];
      3'd3:    pick = above[1];
      3'd4:    pick = below[0] + below[1];
      3'd5:    pick = above[0] + above[1];
      default: pick = '0;
    endcase
    wide = {pick, {AW{1'b0}}} >> (N_LOG2 + 1);
    skip = |wide[SUMW+AW-1:AW];
    addr = wide[AW-1:0];
    neg  = (k >= 3'd4);
  end
endmodule

// File: rtl/ent_threshold_search.sv
`timescale 1ns/1ps
module ent_threshold_search #(
  parameter int SW       = 10,
  parameter int HI_LSB   = 20,
  parameter int N_LOG2   = 4,
  parameter int DW       = 8,
  parameter int AW       = 5,
  parameter int TH_START = 0,
  parameter int TH_STEP  = 16,
  parameter int TH_MAX   = 1008
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          word_valid,
  input  logic [31:0]   word_in,
  output logic          req,
  output logic          done,
  output logic          oe,
  output logic [SW-1:0] best_thr,
  output logic [DW-1:0] best_score
);
  import ent_pkg::*;

  localparam int SUMW = N_LOG2 + 2;
  localparam int ACCW = DW + 4;
  localparam int ONE  = 1 << (DW - 1);
  localparam int LIM  = TH_MAX - TH_STEP;
  localparam logic signed [ACCW-1:0] ONE_S = ACCW'(ONE);

  ent_state_t state;
  logic [SW-1:0]            thr;
  logic [2:0]               k;
  logic signed [ACCW-1:0]   acc, diff, term_s;
  logic                     p_vld, p_neg, p_skip;
  logic [1:0][SW-1:0]       samp;
  logic [1:0][SUMW-1:0]     below, above;
  logic                     take, last_word, clr;
  logic [AW-1:0]            sel_addr;
  logic                     sel_skip, sel_neg;
  logic [DW-1:0]            rom_q, score;
  logic                     is_last, first;
  logic [31-(HI_LSB+SW)+(HI_LSB-SW):0] spare_unused;

  assign samp[0]      = word_in[SW-1:0];
  assign samp[1]      = word_in[HI_LSB +: SW];
  assign spare_unused = {word_in[31:HI_LSB+SW], word_in[HI_LSB-1:SW]};

  assign take = req && word_valid && (state == ST_LOAD);
  assign clr  = start || (state == ST_JUDGE);

  ent_tally #(.SW(SW), .N_LOG2(N_LOG2), .SUMW(SUMW)) u_tally (
    .clk(clk), .rst(rst), .clr(clr), .take(take), .samp(samp), .thr(thr),
    .below(below), .above(above), .last(last_word)
  );

  ent_term_pick #(.N_LOG2(N_LOG2), .AW(AW), .SUMW(SUMW)) u_pick (
    .k(k), .below(below), .above(above),
    .addr(sel_addr), .skip(sel_skip), .neg(sel_neg)
  );

  ent_plogp_rom #(.AW(AW), .DW(DW)) u_rom (
    .clk(clk), .addr(sel_addr), .q(rom_q)
  );

  assign term_s  = p_skip ? '0 : $signed({{(ACCW-DW){1'b0}}, rom_q});
  assign diff    = ONE_S - acc;
  assign is_last = (int'(thr) > LIM);
  assign first   = (thr == SW'(TH_START));

  always_comb begin
    if (diff < 0)          score = '0;
    else if (diff > ONE_S) score = DW'(ONE);
    else                   score = diff[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      req        <= 1'b0;
      done       <= 1'b0;
      oe         <= 1'b0;
      best_thr   <= '0;
      best_score <= '0;
      thr        <= '0;
      k          <= '0;
      acc        <= '0;
      p_vld      <= 1'b0;
      p_neg      <= 1'b0;
      p_skip     <= 1'b0;
    end else begin
      oe <= 1'b0;
      if (start) begin
        state      <= ST_LOAD;
        req        <= 1'b1;
        done       <= 1'b0;
        best_thr   <= '0;
        best_score <= '0;
        thr        <= SW'(TH_START);
        acc        <= '0;
        p_vld      <= 1'b0;
      end else begin
        case (state)
          ST_LOAD: begin
            if (last_word) begin
              state <= ST_CALC;
              req   <= 1'b0;
              k     <= '0;
              acc   <= '0;
              p_vld <= 1'b0;
            end
          end
          ST_CALC: begin
            p_vld  <= (k != 3'(TERMS));
            p_neg  <= sel_neg;
            p_skip <= sel_skip;
            if (p_vld) acc <= p_neg ? acc - term_s : acc + term_s;
            if (k == 3'(TERMS)) state <= ST_JUDGE;
            else                k     <= k + 1'b1;
          end
          ST_JUDGE: begin
            if (first || (score > best_score)) begin
              best_score <= score;
              best_thr   <= thr;
            end
            if (is_last) begin
              state <= ST_FIN;
              done  <= 1'b1;
              oe    <= 1'b1;
            end else begin
              thr   <= thr + SW'(TH_STEP);
              state <= ST_LOAD;
              req   <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ent_search_chk.sv
`timescale 1ns/1ps
module ent_search_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          req,
  input logic          done,
  input logic          oe,
  input logic [DW-1:0] best_score
);
  localparam int ONE = 1 << (DW - 1);

  p_oe_in_done_r9: assert property (@(posedge clk) disable iff (rst)
    oe |-> done);

  p_oe_once_r9: assert property (@(posedge clk) disable iff (rst)
    oe |=> !oe);

  p_oe_at_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> oe);

  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  p_no_req_done_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !req);

  p_start_clear_r7: assert property (@(posedge clk) disable iff (rst)
    start |=> (req && !done && (best_score == '0)));

  p_score_bound_r4: assert property (@(posedge clk) disable iff (rst)
    int'(best_score) <= ONE);
endmodule

bind ent_threshold_search ent_search_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .req(req), .done(done),
  .oe(oe), .best_score(best_score)
);

// File: tb/sim_ent_threshold_search.sv
`timescale 1ns/1ps
module sim_ent_threshold_search;
  localparam int SW = 10, NS = 16, DW = 8;
  localparam int TH_START = 0, TH_STEP = 16, TH_MAX = 1008;

  logic clk = 1'b0;
  logic rst, start, word_valid;
  logic [31:0] word_in;
  logic req, done, oe;
  logic [SW-1:0] best_thr;
  logic [DW-1:0] best_score;

  int checks = 0, errors = 0;
  int c1 [NS];
  int c2 [NS];

  always #2.5 clk = ~clk;

  ent_threshold_search #(.SW(SW), .HI_LSB(20), .N_LOG2(4), .DW(DW), .AW(5),
    .TH_START(TH_START), .TH_STEP(TH_STEP), .TH_MAX(TH_MAX)) u0 (
    .clk(clk), .rst(rst), .start(start), .word_valid(word_valid),
    .word_in(word_in), .req(req), .done(done), .oe(oe),
    .best_thr(best_thr), .best_score(best_score)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // R3: scaled table value for a tally
  function automatic int ref_h(int x);
    int q;
    q = (x * 32) / (2 * NS);
    if (q <= 0 || q >= 32) return 0;
    return $rtoi(128.0 * (real'(q) / 32.0) * ($ln(32.0 / real'(q)) / $ln(2.0)) + 0.5);
  endfunction

  // R2, R4: expected score of one candidate
  function automatic int ref_score(int t);
    int a_lo = 0, a_hi = 0, b_lo = 0, b_hi = 0, de, s;
    foreach (c1[i]) begin
      if (c1[i] >= t) a_hi++; else a_lo++;
      if (c2[i] >= t) b_hi++; else b_lo++;
    end
    de = ref_h(a_lo) + ref_h(a_hi) + ref_h(b_lo) + ref_h(b_hi)
       - ref_h(a_lo + b_lo) - ref_h(a_hi + b_hi);
    s = 128 - de;
    if (s < 0) s = 0;
    if (s > 128) s = 128;
    return s;
  endfunction

  task automatic run_search(input bit stall, input bit poison, input int abort_after);
    int ref_best = 0, ref_thr = 0, t = TH_START, pass = 0;
    bit last;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(req == 1'b1, "R7 req after start", req, 1);
    chk(done == 1'b0, "R7 done after start", done, 0);
    chk(best_score == 0, "R7 best_score cleared", best_score, 0);
    chk(best_thr == 0, "R7 best_thr cleared", best_thr, 0);
    forever begin
      last = (TH_MAX - t) < TH_STEP;
      for (int i = 0; i < NS; ) begin
        @(negedge clk);
        chk(req == 1'b1, "R8 req high while collecting", req, 1);
        if (stall && (($urandom & 3) == 0)) begin
          word_valid = 1'b0;
        end else begin
          word_valid = 1'b1;
          // R1: noise in the unused bit ranges
          word_in = {2'($urandom), 10'(c2[i]), 10'($urandom), 10'(c1[i])};
          i++;
        end
      end
      for (int g = 1; g <= 8; g++) begin
        @(negedge clk);
        word_valid = poison;
        word_in    = $urandom;
        chk(req == 1'b0, "R8 req low during scoring", req, 0);
        chk(done == 1'b0, "R9 done early", done, 0);
      end
      @(negedge clk);
      word_valid = 1'b0;
      if (pass == 0 || ref_score(t) > ref_best) begin
        ref_best = ref_score(t);
        ref_thr  = t;
      end
      chk(best_score == ref_best, "R1 R3 R4 R8 best_score", best_score, ref_best);
      chk(best_thr == ref_thr, "R2 R6 best_thr", best_thr, ref_thr);
      pass++;
      if (abort_after != 0 && pass == abort_after) return;
      if (last) begin
        chk(done == 1'b1, "R5 R9 done after final candidate", done, 1);
        chk(oe == 1'b1, "R9 oe with done", oe, 1);
        chk(req == 1'b0, "R9 req low when done", req, 0);
        chk(pass == (TH_MAX - TH_START) / TH_STEP + 1, "R5 candidate count", pass,
            (TH_MAX - TH_START) / TH_STEP + 1);
        @(negedge clk);
        chk(oe == 1'b0, "R9 oe single cycle", oe, 0);
        chk(done == 1'b1, "R9 done holds", done, 1);
        return;
      end
      chk(done == 1'b0, "R5 done before final candidate", done, 0);
      chk(req == 1'b1, "R8 req back for next candidate", req, 1);
      t += TH_STEP;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; word_valid = 1'b0; word_in = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(req == 1'b0, "R10 reset req", req, 0);
    chk(done == 1'b0, "R10 reset done", done, 0);
    chk(oe == 1'b0, "R10 reset oe", oe, 0);
    chk(best_score == 0, "R10 reset best_score", best_score, 0);
    chk(best_thr == 0, "R10 reset best_thr", best_thr, 0);

    // clean separation, class one low
    foreach (c1[i]) begin c1[i] = 100 + 9 * i; c2[i] = 600 + 19 * i; end
    run_search(1'b0, 1'b0, 0);
    // reversed separation, stalls and ignored words (R8)
    foreach (c1[i]) begin c1[i] = 700 + 11 * i; c2[i] = 50 + 13 * i; end
    run_search(1'b1, 1'b1, 0);
    // R2: samples exactly on a candidate
    foreach (c1[i]) begin c1[i] = 128; c2[i] = 127; end
    run_search(1'b0, 1'b1, 0);
    // overlapping random classes, aborted then rerun (R7)
    foreach (c1[i]) begin c1[i] = 300 + ($urandom % 400); c2[i] = 450 + ($urandom % 400); end
    run_search(1'b1, 1'b0, 5);
    run_search(1'b1, 1'b0, 0);
    // R6: identical classes produce many equal scores
    foreach (c1[i]) begin c1[i] = 64 * i; c2[i] = 64 * i; end
    run_search(1'b0, 1'b0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule